// File: doc/BRIEF.md
# Serial Memory Write Guard

This unit sits beside the command decoder of a 512-byte serial non-volatile memory and owns the state that decides whether the array or the status byte may be reprogrammed. It holds three things: a write-enable latch, a two-bit protection level that is kept across cycles, and a busy flag that is raised while a program cycle runs. The decoder sends it one-cycle strobes for enable, disable, status write, data write start and program completion. It also supplies the write-protect pin level, the target address and the status data byte.

From that state the unit builds the byte returned on a status read. It issues a one-cycle permit pulse when a data write may start, and it exports the current protection level to the array controller. The protection level selects a region of the address space, always ending at the top address, that refuses data writes. A status write changes that level only when its program cycle completes.

Top module: `wr_protect_unit`

## Requirements
- R1: After synchronous reset the status byte is 0x00, the permit output is 0 and the protection level output is 00.
- R2: An enable strobe sets the write-enable latch, seen as status bit 1, only when the write-protect level input is high; with that input low the strobe has no effect.
- R3: The latch is cleared by a disable strobe, and in any cycle in which the write-protect level input is low, whatever else happens.
- R4: A data write strobe raises the permit output for exactly one cycle, on the edge after the strobe, only if write-protect is high, the latch is set, no cycle is running, and the address lies outside the protected region.
- R5: Protection level 00 protects no address, 01 protects 0x180 to 0x1FF, 10 protects 0x100 to 0x1FF, and 11 protects 0x000 to 0x1FF.
- R6: An accepted data or status write raises the busy flag. The program-done strobe then clears both the busy flag and the latch.
- R7: While the busy flag is set, the status byte reads 0xFF.
- R8: An accepted status write copies status data bits 3 and 2 into protection bits 1 and 0 when the program-done strobe arrives. All other data bits are ignored. The protection output shows the new level after that edge.
- R9: When idle, the status byte carries busy in bit 0, the latch in bit 1, protection bit 0 in bit 2 and protection bit 1 in bit 3, with bits 7 to 4 at 0.
- R10: A rejected data or status write leaves the protection level, the latch and the busy flag unchanged.
- R11: While busy, the enable, disable, status write and data write strobes are ignored. A program-done strobe while idle is also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wp_level | input | 1 | Write-protect pin level, high allows programming |
| cmd_wren | input | 1 | Enable strobe |
| cmd_wrdi | input | 1 | Disable strobe |
| cmd_wrsr | input | 1 | Status write strobe |
| cmd_wrdata | input | 1 | Data write start strobe |
| cmd_done | input | 1 | Program cycle completion strobe |
| sr_data | input | 8 | Data byte of a status write |
| wr_addr | input | 9 | Target address of a data write |
| status_o | output | 8 | Status byte for a status read |
| write_ok_o | output | 1 | One-cycle data write permit |
| prot_o | output | 2 | Current protection level |

## Verification
The bench probes the region boundaries at every level: 0x17F against 0x180, 0x0FF against 0x100, and 0x000 at full protection. A comparator cut one bit short would grant a write into a guarded address or refuse a legal one.

A status write is sent with its don't-care bits set, and the protection output is checked while the cycle is still running. A design that decoded the wrong bits, or committed the level early, would show a wrong level on prot_o.

Commands are issued while busy, with write-protect low and with the latch clear. A design that let any of them through would raise the permit, set busy or move the latch, and the status byte after the next completion would show it.

// File: rtl/wpu_pkg.sv
package wpu_pkg;
  localparam int STAT_W = 8;

  typedef enum logic [1:0] {
    LVL_NONE    = 2'b00,
    LVL_QUARTER = 2'b01,
    LVL_HALF    = 2'b10,
    LVL_ALL     = 2'b11
  } prot_lvl_e;
endpackage

// File: rtl/wpu_range_cmp.sv
module wpu_range_cmp
  import wpu_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  prot_lvl_e         lvl,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam int TOP = ADDR_W - 1;

  logic top_quarter;
  logic top_half;

  generate
    if (ADDR_W >= 2) begin : g_wide
      assign top_quarter = addr[TOP] & addr[TOP-1];
    end else begin : g_narrow
      assign top_quarter = addr[TOP];
    end
  endgenerate
  assign top_half = addr[TOP];

  always_comb begin
    unique case (lvl)
      LVL_NONE:    hit = 1'b0;
      LVL_QUARTER: hit = top_quarter;
      LVL_HALF:    hit = top_half;
      default:     hit = 1'b1;
    endcase
  end
endmodule

// File: rtl/wpu_wen_latch.sv
module wpu_wen_latch (
  input  logic clk,
  input  logic rst,
  input  logic wp_level,
  input  logic busy,
  input  logic set_req,
  input  logic clr_req,
  input  logic cycle_end,
  output logic wen
);
  logic wen_q;

  always_ff @(posedge clk) begin
    if (rst)                wen_q <= 1'b0;
    else if (!wp_level)     wen_q <= 1'b0;
    else if (cycle_end)     wen_q <= 1'b0;
    else if (busy)          wen_q <= wen_q;
    else if (clr_req)       wen_q <= 1'b0;
    else if (set_req)       wen_q <= 1'b1;
  end

  assign wen = wen_q;

  // R3
  wp_low_clears_chk: assert property (@(posedge clk) disable iff (rst)
    !wp_level |=> !wen_q);
  // R6
  end_clears_chk: assert property (@(posedge clk) disable iff (rst)
    cycle_end |=> !wen_q);
  // R11
  busy_holds_set_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !cycle_end && !wen_q) |=> !wen_q);
endmodule

// File: rtl/wpu_state.sv
module wpu_state
  import wpu_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      accept_data,
  input  logic      accept_sr,
  input  logic [1:0] sr_lvl,
  input  logic      done,
  output logic      busy,
  output prot_lvl_e lvl
);
  logic       busy_q;
  logic       sr_pend_q;
  logic [1:0] pend_lvl_q;
  logic [1:0] lvl_q;
  logic       cycle_end;

  assign cycle_end = done & busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q     <= 1'b0;
      sr_pend_q  <= 1'b0;
      pend_lvl_q <= 2'b00;
      lvl_q      <= 2'b00;
    end else if (cycle_end) begin
      busy_q    <= 1'b0;
      sr_pend_q <= 1'b0;
      if (sr_pend_q) lvl_q <= pend_lvl_q;
    end else if (!busy_q && (accept_data || accept_sr)) begin
      busy_q     <= 1'b1;
      sr_pend_q  <= accept_sr;
      pend_lvl_q <= sr_lvl;
    end
  end

  assign busy = busy_q;
  assign lvl  = prot_lvl_e'(lvl_q);

  // R8
  lvl_only_at_end_chk: assert property (@(posedge clk) disable iff (rst)
    !cycle_end |=> $stable(lvl_q));
  // R6
  busy_clear_chk: assert property (@(posedge clk) disable iff (rst)
    cycle_end |=> !busy_q);
  // R11
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !done) |=> busy_q);
endmodule

// File: rtl/wr_protect_unit.sv
module wr_protect_unit
  import wpu_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wp_level,
  input  logic              cmd_wren,
  input  logic              cmd_wrdi,
  input  logic              cmd_wrsr,
  input  logic              cmd_wrdata,
  input  logic              cmd_done,
  input  logic [STAT_W-1:0] sr_data,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic [STAT_W-1:0] status_o,
  output logic              write_ok_o,
  output logic [1:0]        prot_o
);
  localparam int PAD_W = STAT_W - 4;

  logic      wen;
  logic      busy;
  logic      hit;
  prot_lvl_e lvl;
  logic      may_program;
  logic      accept_data;
  logic      accept_sr;
  logic      ok_q;
  logic      unused_sr_bits;

  assign unused_sr_bits = ^{sr_data[STAT_W-1:4], sr_data[1:0]};

  wpu_range_cmp #(.ADDR_W(ADDR_W)) u_range (
    .lvl  (lvl),
    .addr (wr_addr),
    .hit  (hit)
  );

  assign may_program = wp_level & wen & ~busy;
  assign accept_data = cmd_wrdata & may_program & ~hit;
  assign accept_sr   = cmd_wrsr & may_program;

  wpu_wen_latch u_latch (
    .clk       (clk),
    .rst       (rst),
    .wp_level  (wp_level),
    .busy      (busy),
    .set_req   (cmd_wren),
    .clr_req   (cmd_wrdi),
    .cycle_end (cmd_done & busy),
    .wen       (wen)
  );

  wpu_state u_state (
    .clk         (clk),
    .rst         (rst),
    .accept_data (accept_data),
    .accept_sr   (accept_sr),
    .sr_lvl      (sr_data[3:2]),
    .done        (cmd_done),
    .busy        (busy),
    .lvl         (lvl)
  );

  always_ff @(posedge clk) begin
    if (rst) ok_q <= 1'b0;
    else     ok_q <= accept_data;
  end

  assign write_ok_o = ok_q;
  assign prot_o     = lvl;
  assign status_o   = busy ? {STAT_W{1'b1}} : {{PAD_W{1'b0}}, lvl, wen, 1'b0};

  // R4
  ok_needs_wp_chk: assert property (@(posedge clk) disable iff (rst)
    write_ok_o |-> $past(wp_level && cmd_wrdata));
  // R6
  ok_sets_busy_chk: assert property (@(posedge clk) disable iff (rst)
    write_ok_o |-> busy);
  // R4
  ok_single_chk: assert property (@(posedge clk) disable iff (rst)
    write_ok_o |=> !write_ok_o);
  // R5
  ok_outside_chk: assert property (@(posedge clk) disable iff (rst)
    write_ok_o |-> $past(!hit));
endmodule

// File: tb/sim_wr_protect_unit.sv
module sim_wr_protect_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wp_level = 1'b1;
  logic       cmd_wren = 1'b0, cmd_wrdi = 1'b0, cmd_wrsr = 1'b0;
  logic       cmd_wrdata = 1'b0, cmd_done = 1'b0;
  logic [7:0] sr_data = 8'h00;
  logic [8:0] wr_addr = 9'h000;
  logic [7:0] status_o;
  logic       write_ok_o;
  logic [1:0] prot_o;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  localparam int OP_IDLE = 0, OP_WREN = 1, OP_WRDI = 2, OP_WRSR = 3,
                 OP_WRITE = 4, OP_DONE = 5;

  typedef struct {
    logic [7:0] st;
    logic       ok;
    logic [1:0] pr;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  wr_protect_unit u0 (
    .clk(clk), .rst(rst), .wp_level(wp_level),
    .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi), .cmd_wrsr(cmd_wrsr),
    .cmd_wrdata(cmd_wrdata), .cmd_done(cmd_done),
    .sr_data(sr_data), .wr_addr(wr_addr),
    .status_o(status_o), .write_ok_o(write_ok_o), .prot_o(prot_o)
  );

  // monitor: compares each expectation just after the edge that produces it
  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      tests++;
      if (status_o !== e.st || write_ok_o !== e.ok || prot_o !== e.pr) begin
        fails++;
        $display("FAIL %s: status=%h ok=%b prot=%b expected status=%h ok=%b prot=%b",
                 e.tag, status_o, write_ok_o, prot_o, e.st, e.ok, e.pr);
      end
    end
  end

  task automatic step(input int op, input logic wp, input logic [7:0] sd,
                      input logic [8:0] a, input logic [7:0] es,
                      input logic eok, input logic [1:0] ep, input string tag);
    exp_t e;
    @(negedge clk);
    wp_level   = wp;
    cmd_wren   = (op == OP_WREN);
    cmd_wrdi   = (op == OP_WRDI);
    cmd_wrsr   = (op == OP_WRSR);
    cmd_wrdata = (op == OP_WRITE);
    cmd_done   = (op == OP_DONE);
    sr_data    = sd;
    wr_addr    = a;
    e.st = es; e.ok = eok; e.pr = ep; e.tag = tag;
    sb.push_back(e);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    step(OP_IDLE, 1, 8'h00, 9'h000, 8'h00, 0, 2'b00, "R1");
    // R2 enable only with WP high
    step(OP_WREN, 0, 8'h00, 9'h000, 8'h00, 0, 2'b00, "R2");
    step(OP_WREN, 1, 8'h00, 9'h000, 8'h02, 0, 2'b00, "R2");
    // R3 disable and WP low clear the latch
    step(OP_WRDI, 1, 8'h00, 9'h000, 8'h00, 0, 2'b00, "R3");
    step(OP_WREN, 1, 8'h00, 9'h000, 8'h02, 0, 2'b00, "R2");
    step(OP_IDLE, 0, 8'h00, 9'h000, 8'h00, 0, 2'b00, "R3");
    // R10 write without latch rejected
    step(OP_WRITE, 1, 8'h00, 9'h005, 8'h00, 0, 2'b00, "R10");
    // R4 R6 R7 accepted write at top address, level none
    step(OP_WREN, 1, 8'h00, 9'h000, 8'h02, 0, 2'b00, "R2");
    step(OP_WRITE, 1, 8'h00, 9'h1FF, 8'hFF, 1, 2'b00, "R4");
    step(OP_IDLE, 1, 8'h00, 9'h000, 8'hFF, 0, 2'b00, "R7");
    // R11 commands while busy ignored
    step(OP_WRDI, 1, 8'h00, 9'h000, 8'hFF, 0, 2'b00, "R11");
    step(OP_WRSR, 1, 8'h0C, 9'h000, 8'hFF, 0, 2'b00, "R11");
    step(OP_WRITE, 1, 8'h00, 9'h010, 8'hFF, 0, 2'b00, "R11");
    step(OP_DONE, 1, 8'h00, 9'h000, 8'h00, 0, 2'b00, "R6");
    // R8 R9 status write to level 01 with don't-care bits set
    step(OP_WREN, 1, 8'h00, 9'h000, 8'h02, 0, 2'b00, "R2");
    step(OP_WRSR, 1, 8'hF7, 9'h000, 8'hFF, 0, 2'b00, "R8");
    step(OP_DONE, 1, 8'h00, 9'h000, 8'h04, 0, 2'b01, "R9");
    // R5 level 01 boundary
    step(OP_WREN, 1, 8'h00, 9'h000, 8'h06, 0, 2'b01, "R9");
    step(OP_WRITE, 1, 8'h00, 9'h180, 8'h06, 0, 2'b01, "R5");
    step(OP_WRITE, 1, 8'h00, 9'h17F, 8'hFF, 1, 2'b01, "R5");
    step(OP_DONE, 1, 8'h00, 9'h000, 8'h04, 0, 2'b01, "R6");
    // R5 level 10 boundary
    step(OP_WREN, 1, 8'h00, 9'h000, 8'h06, 0, 2'b01, "R2");
    step(OP_WRSR, 1, 8'h08, 9'h000, 8'hFF, 0, 2'b01, "R8");
    step(OP_DONE, 1, 8'h00, 9'h000, 8'h08, 0, 2'b10, "R8");
    step(OP_WREN, 1, 8'h00, 9'h000, 8'h0A, 0, 2'b10, "R9");
    step(OP_WRITE, 1, 8'h00, 9'h100, 8'h0A, 0, 2'b10, "R5");
    step(OP_WRITE, 1, 8'h00, 9'h0FF, 8'hFF, 1, 2'b10, "R5");
    step(OP_DONE, 1, 8'h00, 9'h000, 8'h08, 0, 2'b10, "R6");
    // R5 level 11 protects everything
    step(OP_WREN, 1, 8'h00, 9'h000, 8'h0A, 0, 2'b10, "R2");
    step(OP_WRSR, 1, 8'h0C, 9'h000, 8'hFF, 0, 2'b10, "R8");
    step(OP_DONE, 1, 8'h00, 9'h000, 8'h0C, 0, 2'b11, "R8");
    step(OP_WREN, 1, 8'h00, 9'h000, 8'h0E, 0, 2'b11, "R2");
    step(OP_WRITE, 1, 8'h00, 9'h000, 8'h0E, 0, 2'b11, "R5");
    step(OP_WRITE, 1, 8'h00, 9'h1FF, 8'h0E, 0, 2'b11, "R5");
    // R10 status write rejected by WP low, then by clear latch
    step(OP_WRSR, 0, 8'h00, 9'h000, 8'h0C, 0, 2'b11, "R10");
    step(OP_WRSR, 1, 8'h00, 9'h000, 8'h0C, 0, 2'b11, "R10");
    step(OP_DONE, 1, 8'h00, 9'h000, 8'h0C, 0, 2'b11, "R11");
    // back to level 00
    step(OP_WREN, 1, 8'h00, 9'h000, 8'h0E, 0, 2'b11, "R2");
    step(OP_WRSR, 1, 8'hF3, 9'h000, 8'hFF, 0, 2'b11, "R8");
    step(OP_DONE, 1, 8'h00, 9'h000, 8'h00, 0, 2'b00, "R8");
    step(OP_DONE, 1, 8'h00, 9'h000, 8'h00, 0, 2'b00, "R11");
    step(OP_IDLE, 1, 8'h00, 9'h000, 8'h00, 0, 2'b00, "R9");
    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #200us;
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule